// File: doc/BRIEF.md
# Serial Nine-Tap Convolution Multiply-Accumulate Unit

This block computes one filtered pixel of a 3x3 texture kernel. It multiplies nine image samples by nine stored kernel coefficients and sums the products. One signed multiplier and one adder, placed in series, are reused over nine clock cycles. This replaces a bank of nine parallel multipliers and a tree of eight adders, so the block is slower but much smaller. The coefficients sit in a small read-only table with sixteen slots. Nine slots hold the kernel and the other seven read as zero.

An outside controller starts a run by raising `startIn`. On the edge where it sees the rise, and on each of the next eight edges, it presents a coefficient index. The image memory returns the matching pixel one clock later. The block delays its own step strobe by one clock so that each pixel meets its own coefficient. After the ninth product, the block loads the sum into the result register, raises `readyOut` and pulses `setOut`. The controller then lowers `startIn` before it starts the next run.

Top module: `conv9_mac`

## Requirements
- R1: While `rstN` is low, `resultOut` is zero and `readyOut` and `setOut` are low.
- R2: A run starts only on a clock edge where `startIn` is sampled high after being low on the edge before. A constant level of `startIn` starts nothing. A rise that arrives while a run is in progress is ignored and does not change the timing or the value of that run.
- R3: Call the edge where the rise is seen edge 0. The block samples `coefIdx` on edges 0 to 8. It samples the pixel for the index taken at edge k on edge k+1. Indices presented after edge 8, and the pixel present at edge 0, have no effect.
- R4: The coefficient table holds signed values. Indices 0, 2, 6 and 8 hold -1024. Indices 1 and 7 hold 2048. Indices 3 and 5 hold -4096. Index 4 holds 16384. Indices 9 to 15 read as zero.
- R5: `resultOut` is the exact 36-bit two's-complement sum of the nine signed 16x16 products, with no overflow. For example, index 4 used nine times with pixel -32768 gives -4831838208.
- R6: `resultOut` changes and `readyOut` rises on edge 9. `readyOut` is low before edge 9. `setOut` is high for exactly the one cycle after edge 9.
- R7: The running sum is cleared at the start of every run, so a result never depends on an earlier run.
- R8: `resultOut` keeps its value until the next run completes, including during that run.
- R9: `readyOut` stays high while `startIn` is held high. It clears on the first edge that samples `startIn` low, except on a completion edge.
- R10: Once started, a run always completes all nine steps, even if `startIn` falls during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Convolution request; a rise starts a run |
| coefIdx | input | 4 | Coefficient table index for the current step |
| pixelIn | input | 16 | Signed pixel; arrives one clock after its index |
| resultOut | output | 36 | Signed filtered pixel of the last completed run |
| readyOut | output | 1 | Completion level, held until start is lowered |
| setOut | output | 1 | One-cycle completion strobe |

## Verification
The embedded assertions check, on every cycle:
- `setOut` is a single-cycle pulse that appears only together with `readyOut`.
- `readyOut` falls when `startIn` is low.
- The result register changes only on a commit.
- A step strobe appears only inside a run.
- The issue counter never passes nine.
- The accumulator never wraps its sign.

Only the bench scenarios can show the parts that depend on values and timing:
- The exact sum for each kernel slot.
- That unused slots read as zero.
- The one-clock pairing of pixel and index.
- Completion on edge 9.
- That rises during a run are ignored.
- That a run completes after start has been dropped.

// File: rtl/conv9_pkg.sv
package conv9_pkg;

  // Strobes from control to datapath, aligned to the pixel cycle.
  typedef struct packed {
    logic stepEn;   // accumulate pixelIn * coefficient this cycle
    logic clearAcc; // first step of a run: start from zero
    logic commit;   // last step of a run: load the result register
  } macCtrl_t;

endpackage

// File: rtl/conv9_coef_rom.sv
module conv9_coef_rom #(
  parameter int DATA_W    = 16,
  parameter int TAPS      = 9,
  parameter int ROM_DEPTH = 16,
  localparam int IDX_W    = $clog2(ROM_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [IDX_W-1:0]         coefIdx,
  output logic signed [DATA_W-1:0] coefOut
);

  // Symmetric 3x3 band-pass kernel, row major.
  function automatic logic signed [DATA_W-1:0] kernelAt(input int slot);
    case (slot)
      0, 2, 6, 8: kernelAt = DATA_W'(-1024);
      1, 7:       kernelAt = DATA_W'(2048);
      3, 5:       kernelAt = DATA_W'(-4096);
      4:          kernelAt = DATA_W'(16384);
      default:    kernelAt = '0;
    endcase
  endfunction

  logic signed [DATA_W-1:0] coefTable [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : gSlot
    if (g < TAPS) begin : gUsed
      assign coefTable[g] = kernelAt(g);
    end else begin : gSpare
      assign coefTable[g] = '0;
    end
  end

  // Registered read: coefficient lines up with the pixel one clock later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coefOut <= '0;
    else       coefOut <= coefTable[coefIdx];
  end

endmodule

// File: rtl/conv9_mac_ctrl.sv
module conv9_mac_ctrl
  import conv9_pkg::*;
#(
  parameter int TAPS    = 9,
  localparam int CNT_W  = $clog2(TAPS + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  output macCtrl_t macCtrl,
  output logic     readyOut,
  output logic     setOut
);

  logic             startPrev;
  logic             busy;
  logic [CNT_W-1:0] issueCnt;
  logic [CNT_W-1:0] stepCnt;
  logic             stepPipe;   // one-clock buffer of the issue strobe
  logic             firstPipe;
  logic             beginRun;
  logic             issueNow;
  logic             lastStep;

  assign beginRun = startIn && !startPrev && !busy;
  assign issueNow = beginRun || (busy && (issueCnt < CNT_W'(TAPS)));
  assign lastStep = stepPipe &&
                    (firstPipe ? (TAPS == 1) : (stepCnt == CNT_W'(TAPS - 1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev <= 1'b0;
      busy      <= 1'b0;
      issueCnt  <= '0;
      stepCnt   <= '0;
      stepPipe  <= 1'b0;
      firstPipe <= 1'b0;
      readyOut  <= 1'b0;
      setOut    <= 1'b0;
    end else begin
      startPrev <= startIn;
      stepPipe  <= issueNow;
      firstPipe <= beginRun;

      if (beginRun) begin
        busy     <= 1'b1;
        issueCnt <= CNT_W'(1);
      end else if (busy && (issueCnt < CNT_W'(TAPS))) begin
        issueCnt <= issueCnt + 1'b1;
      end

      if (stepPipe) stepCnt <= firstPipe ? CNT_W'(1) : stepCnt + 1'b1;

      if (lastStep) busy <= 1'b0;

      setOut <= lastStep;
      if (lastStep)      readyOut <= 1'b1;
      else if (!startIn) readyOut <= 1'b0;
    end
  end

  assign macCtrl.stepEn   = stepPipe;
  assign macCtrl.clearAcc = firstPipe;
  assign macCtrl.commit   = lastStep;

  AST_SET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    setOut |=> !setOut); // R6
  AST_SET_WITH_READY: assert property (@(posedge clk) disable iff (!rstN)
    setOut |-> readyOut); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && !startIn && !lastStep) |=> !readyOut); // R9
  AST_STEP_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    stepPipe |-> busy); // R10
  AST_ISSUE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    issueCnt <= CNT_W'(TAPS)); // R3

endmodule

// File: rtl/conv9_mac_datapath.sv
module conv9_mac_datapath
  import conv9_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TAPS    = 9,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  macCtrl_t                 macCtrl,
  input  logic signed [DATA_W-1:0] pixelIn,
  input  logic signed [DATA_W-1:0] coefIn,
  output logic signed [ACC_W-1:0]  resultOut
);

  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  accReg;
  logic signed [ACC_W-1:0]  accNext;

  // One shared multiplier feeding one adder.
  assign product = pixelIn * coefIn;
  assign prodExt = {{(ACC_W - PROD_W){product[PROD_W-1]}}, product};
  assign accNext = (macCtrl.clearAcc ? '0 : accReg) + prodExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      resultOut <= '0;
    end else begin
      if (macCtrl.stepEn) accReg <= accNext;
      if (macCtrl.commit) resultOut <= accNext;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !macCtrl.commit |=> $stable(resultOut)); // R8
  AST_COMMIT_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    macCtrl.commit |-> macCtrl.stepEn); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (macCtrl.stepEn && !macCtrl.clearAcc &&
     (accReg[ACC_W-1] == prodExt[ACC_W-1]))
    |-> (accNext[ACC_W-1] == accReg[ACC_W-1])); // R5

endmodule

// File: rtl/conv9_mac.sv
module conv9_mac
  import conv9_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TAPS      = 9,
  parameter int ROM_DEPTH = 16,
  localparam int IDX_W    = $clog2(ROM_DEPTH),
  localparam int ACC_W    = 2 * DATA_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startIn,
  input  logic [IDX_W-1:0]         coefIdx,
  input  logic signed [DATA_W-1:0] pixelIn,
  output logic signed [ACC_W-1:0]  resultOut,
  output logic                     readyOut,
  output logic                     setOut
);

  macCtrl_t                 macCtrl;
  logic signed [DATA_W-1:0] coefVal;

  conv9_coef_rom #(.DATA_W(DATA_W), .TAPS(TAPS), .ROM_DEPTH(ROM_DEPTH)) uRom (
    .clk(clk), .rstN(rstN), .coefIdx(coefIdx), .coefOut(coefVal)
  );

  conv9_mac_ctrl #(.TAPS(TAPS)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .macCtrl(macCtrl), .readyOut(readyOut), .setOut(setOut)
  );

  conv9_mac_datapath #(.DATA_W(DATA_W), .TAPS(TAPS)) uPath (
    .clk(clk), .rstN(rstN), .macCtrl(macCtrl),
    .pixelIn(pixelIn), .coefIn(coefVal), .resultOut(resultOut)
  );

endmodule

// File: tb/conv9_mac_test.sv
module conv9_mac_test;

  localparam int NV = 4;
  // Mode 0: start held through run; 1: start dropped at edge 2 (R10);
  // 2: start dropped at edge 2 and raised again at edge 4 (R2).
  localparam logic [0:8][3:0] VEC_IDX [NV] = '{
    '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8},
    '{4'd8, 4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
    '{4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4},
    '{4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15, 4'd4, 4'd1}
  };
  localparam logic [0:8][15:0] VEC_PIX [NV] = '{
    '{16'd100, 16'd200, 16'd300, 16'd400, 16'd500, 16'd600, 16'd700, 16'd800, 16'd900},
    '{16'hFF38, 16'd1234, 16'h8001, 16'd77, 16'h7FFF, 16'hFFFF, 16'd5, 16'hC000, 16'd321},
    '{16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
    '{16'd1000, 16'd1000, 16'd1000, 16'd1000, 16'd1000, 16'd1000, 16'd1000, 16'd3, 16'hFFFE}
  };
  localparam int VEC_MODE [NV] = '{0, 1, 0, 2};

  logic               clk = 1'b0;
  logic               rstN;
  logic               startIn;
  logic [3:0]         coefIdx;
  logic signed [15:0] pixelIn;
  logic signed [35:0] resultOut;
  logic               readyOut;
  logic               setOut;

  int checks = 0;
  int failures = 0;
  longint prevResult = 0;

  always #5 clk = ~clk;

  conv9_mac uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .coefIdx(coefIdx),
    .pixelIn(pixelIn), .resultOut(resultOut), .readyOut(readyOut), .setOut(setOut)
  );

  // Coefficient values as stated in R4.
  function automatic longint coefOf(input logic [3:0] i);
    case (i)
      4'd0, 4'd2, 4'd6, 4'd8: coefOf = -1024;
      4'd1, 4'd7:             coefOf = 2048;
      4'd3, 4'd5:             coefOf = -4096;
      4'd4:                   coefOf = 16384;
      default:                coefOf = 0;
    endcase
  endfunction

  function automatic longint expectSum(input logic [0:8][3:0] ix,
                                       input logic [0:8][15:0] px);
    longint s = 0;
    for (int k = 0; k < 9; k++) s += longint'($signed(px[k])) * coefOf(ix[k]);
    return s;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runConv(input logic [0:8][3:0] ix, input logic [0:8][15:0] px,
                         input int mode);
    longint exp = expectSum(ix, px);
    @(negedge clk);
    startIn = 1'b1; coefIdx = ix[0]; pixelIn = 16'sh7777; // junk pixel at edge 0 (R3)
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      coefIdx = (k < 9) ? ix[k] : 4'd4;                    // junk index after edge 8 (R3)
      pixelIn = px[k-1];
      if (mode != 0 && k == 2) startIn = 1'b0;
      if (mode == 2 && k == 4) startIn = 1'b1;             // rise mid-run ignored (R2)
      if (k == 5) chk("R8 result held during run", resultOut, prevResult);
    end
    chk("R6 ready low before edge 9", readyOut, 0);
    chk("R6 set low before edge 9", setOut, 0);
    @(negedge clk);
    pixelIn = 16'sh7777;
    chk("R5 result sum", resultOut, exp);
    chk("R6 ready at edge 9", readyOut, 1);
    chk("R6 set at edge 9", setOut, 1);
    @(negedge clk);
    chk("R6 set one cycle", setOut, 0);
    if (mode == 1) begin
      chk("R10 ready cleared, start low", readyOut, 0);
    end else begin
      for (int h = 0; h < 3; h++) begin
        chk("R9 ready held with start high", readyOut, 1);
        chk("R8 result stable after run", resultOut, exp);
        @(negedge clk);
      end
      startIn = 1'b0;
      @(negedge clk);
      chk("R9 ready cleared on start low", readyOut, 0);
    end
    for (int h = 0; h < 3; h++) @(negedge clk);
    chk("R2 no new run without rise", setOut, 0);
    chk("R8 result stable when idle", resultOut, exp);
    prevResult = exp;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; startIn = 1'b0; coefIdx = '0; pixelIn = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset result", resultOut, 0);
    chk("R1 reset ready", readyOut, 0);
    chk("R1 reset set", setOut, 0);
    rstN = 1'b1;
    for (int h = 0; h < 5; h++) @(negedge clk);
    chk("R2 idle with start low", readyOut, 0);
    // R7: consecutive runs each match their own sum.
    for (int v = 0; v < NV; v++) runConv(VEC_IDX[v], VEC_PIX[v], VEC_MODE[v]);
    // R4: a single nonzero pixel against each used slot.
    for (int s = 0; s < 9; s++) begin
      logic [0:8][3:0] ix;
      logic [0:8][15:0] px;
      for (int k = 0; k < 9; k++) begin ix[k] = 4'(s); px[k] = 16'd0; end
      px[s] = 16'd1;
      runConv(ix, px, 0);
      chk("R4 coefficient slot", resultOut, coefOf(4'(s)));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule